// File: doc/BRIEF.md
# Serial-Bus Wiper Position Controller

This block is a two-wire serial slave (I2C style, open-drain data line) that owns a 7-bit volatile wiper position and turns it into a one-hot selection of 128 resistor taps. A bus master can load the position, read it back with a combined transfer, or nudge it up and down with a streaming step mode. The step mode has its own slave address. After the register byte, every SCL clock carries one direction bit and there are no acknowledge slots.

SCL and SDA are brought into the system clock domain through two-flop synchronisers. START and STOP are found from the synchronised lines. The block pulls SDA low through a single drive-enable output, which the pad turns into an open-drain driver. At reset the position loads from an input port that holds the stored default value. The tap select output is registered and always agrees with the held position.

An access byte at register 0x02 chooses what register 0x00 writes reach. Only while that byte holds 0x80 do data writes to register 0x00 reach the wiper.

Top module: `wiper_i2c_ctrl`

## Requirements
- R1: In reset the wiper position loads from `default_pos` and SDA is released (`sda_oe` = 0).
- R2: A write transfer (START, byte 0x50, register byte 0x00, data byte, STOP) is acknowledged on all three bytes. It sets the position to data bits 6:0, and data bit 7 is ignored.
- R3: A combined read (START, 0x50, 0x00, repeated START, 0x51) is acknowledged on every address and register byte. The slave then shifts out a byte, MSB first, whose bit 7 is 0 and whose bits 6:0 are the position.
- R4: A write to register 0x02 stores the access byte, which resets to 0x80. A data write to register 0x00 changes the position only while the access byte equals 0x80, and it is still acknowledged otherwise.
- R5: After START, byte 0x58 and register byte 0x00 (both acknowledged), each full SCL clock (rising then falling edge) steps the position. SDA high at the rising edge steps it up by one, and SDA low steps it down by one. SDA is never pulled low in this phase. A STOP ends the phase without a further step.
- R6: Stepping saturates: up at 127 stays 127, down at 0 stays 0.
- R7: An address byte other than 0x50, 0x51 or 0x58 is not acknowledged. So is a register byte other than 0x00 or 0x02, or other than 0x00 after 0x58. The slave then leaves SDA released and changes nothing until the next START.
- R8: A START at any point restarts address reception, and a STOP returns the slave to idle. A data byte cut short by either has no effect.
- R9: `tap_sel` is one-hot with its single set bit at index `wiper_pos`, updated in the same clock cycle as the position.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | SCL line as seen at the pad |
| sda_i | input | 1 | SDA line as seen at the pad |
| default_pos | input | 7 | Stored default position loaded at reset |
| sda_oe | output | 1 | High pulls SDA low (open-drain enable) |
| wiper_pos | output | 7 | Current wiper position |
| tap_sel | output | 128 | One-hot tap switch select |

## Verification
The assertions assume SDA changes only while SCL is low, except where the master makes a START or STOP. They also assume each SCL level lasts longer than the synchroniser delay of three system clocks. The bench master holds every SCL phase for five system clocks and moves SDA only in the low phase, except inside its START and STOP tasks. Random operations mix writes, reads, access-byte changes, step streams and stray addresses. Directed cases cover both saturation ends and aborted bytes.

// File: rtl/wiper_pkg.sv
package wiper_pkg;
  parameter int unsigned POS_W = 7;
  localparam int unsigned TAP_N = 1 << POS_W;

  typedef logic [POS_W-1:0] pos_t;
  typedef logic [TAP_N-1:0] tap_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_REG, ST_DATA, ST_ACK, ST_TX, ST_INCDEC, ST_IGNORE
  } ctl_state_e;

  // One saturating step toward the requested end.
  function automatic pos_t sat_step(pos_t cur, logic up);
    pos_t top;
    top = '1;
    if (up) return (cur == top) ? cur : cur + 1'b1;
    return (cur == '0) ? cur : cur - 1'b1;
  endfunction

  function automatic tap_t tap_onehot(pos_t cur);
    tap_t v;
    v = '0;
    v[cur] = 1'b1;
    return v;
  endfunction
endpackage

// File: rtl/wiper_bus_sync.sv
module wiper_bus_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  // [0] first stage, [1] synchronised, [2] one cycle older
  logic [2:0] scl_p, sda_p;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_p <= '1;
      sda_p <= '1;
    end else begin
      scl_p <= {scl_p[1:0], scl_i};
      sda_p <= {sda_p[1:0], sda_i};
    end
  end

  assign sda_s     = sda_p[1];
  assign scl_rise  = scl_p[1] & ~scl_p[2];
  assign scl_fall  = ~scl_p[1] & scl_p[2];
  assign start_det = scl_p[1] & scl_p[2] & sda_p[2] & ~sda_p[1];
  assign stop_det  = scl_p[1] & scl_p[2] & ~sda_p[2] & sda_p[1];
endmodule

// File: rtl/wiper_proto_fsm.sv
module wiper_proto_fsm
  import wiper_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR  = 7'h28,
  parameter logic [7:0] INC_BYTE  = 8'h58,
  parameter logic [7:0] WIPER_REG = 8'h00,
  parameter logic [7:0] ACC_REG   = 8'h02,
  parameter logic [7:0] ACC_SEL   = 8'h80
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sda_s,
  input  logic scl_rise,
  input  logic scl_fall,
  input  logic start_det,
  input  logic stop_det,
  input  pos_t pos,
  output logic sda_drive,
  output logic load_en,
  output pos_t load_val,
  output logic step_en,
  output logic step_up
);
  localparam int unsigned CNT_W = 3;
  localparam logic [CNT_W-1:0] LAST_BIT = '1;

  ctl_state_e state, after_ack, ack_next;
  logic [CNT_W-1:0] bit_cnt;
  logic       got8;      // byte complete, or step bit pending in step mode
  logic [7:0] shreg;
  logic       inc_mode;
  logic [7:0] reg_ptr;
  logic [7:0] acc_reg;
  logic       ack_ok;
  logic       bus_evt;
  logic       byte_done;

  assign bus_evt   = start_det | stop_det;
  assign byte_done = (state == ST_ADDR || state == ST_REG || state == ST_DATA)
                     && scl_fall && got8 && !bus_evt;

  // Decide whether the finished byte is acknowledged and where it leads.
  always_comb begin
    ack_ok   = 1'b0;
    ack_next = ST_IGNORE;
    unique case (state)
      ST_ADDR: begin
        if (shreg == {DEV_ADDR, 1'b0} || shreg == INC_BYTE) begin
          ack_ok = 1'b1; ack_next = ST_REG;
        end else if (shreg == {DEV_ADDR, 1'b1}) begin
          ack_ok = 1'b1; ack_next = ST_TX;
        end
      end
      ST_REG: begin
        if (inc_mode) begin
          if (shreg == WIPER_REG) begin ack_ok = 1'b1; ack_next = ST_INCDEC; end
        end else if (shreg == WIPER_REG || shreg == ACC_REG) begin
          ack_ok = 1'b1; ack_next = ST_DATA;
        end
      end
      ST_DATA: ack_ok = 1'b1;
      default: ack_ok = 1'b0;
    endcase
  end

  assign load_en  = byte_done && state == ST_DATA && reg_ptr == WIPER_REG && acc_reg == ACC_SEL;
  assign load_val = shreg[POS_W-1:0];
  assign step_en  = state == ST_INCDEC && scl_fall && got8 && !bus_evt;
  assign step_up  = shreg[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE; after_ack <= ST_IDLE; bit_cnt <= '0; got8 <= 1'b0;
      shreg <= '0; sda_drive <= 1'b0; inc_mode <= 1'b0; reg_ptr <= '0; acc_reg <= ACC_SEL;
    end else if (start_det) begin
      state <= ST_ADDR; bit_cnt <= '0; got8 <= 1'b0; sda_drive <= 1'b0;
    end else if (stop_det) begin
      state <= ST_IDLE; got8 <= 1'b0; sda_drive <= 1'b0;
    end else begin
      unique case (state)
        ST_ADDR, ST_REG, ST_DATA: begin
          if (scl_rise && !got8) begin
            shreg   <= {shreg[6:0], sda_s};
            bit_cnt <= bit_cnt + 1'b1;
            if (bit_cnt == LAST_BIT) got8 <= 1'b1;
          end else if (byte_done) begin
            got8 <= 1'b0;
            bit_cnt <= '0;
            if (state == ST_ADDR) inc_mode <= (shreg == INC_BYTE);
            if (state == ST_REG) reg_ptr <= shreg;
            if (state == ST_DATA && reg_ptr == ACC_REG) acc_reg <= shreg;
            if (ack_ok) begin
              sda_drive <= 1'b1; state <= ST_ACK; after_ack <= ack_next;
            end else begin
              state <= ST_IGNORE;
            end
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            state <= after_ack; bit_cnt <= '0; got8 <= 1'b0;
            if (after_ack == ST_TX) begin
              shreg <= {1'b0, pos};
              sda_drive <= 1'b1;           // bit 7 is always 0
            end else begin
              sda_drive <= 1'b0;
            end
          end
        end
        ST_TX: begin
          if (scl_rise) begin
            bit_cnt <= bit_cnt + 1'b1;
            if (bit_cnt == LAST_BIT) got8 <= 1'b1;
          end else if (scl_fall) begin
            if (got8) begin
              sda_drive <= 1'b0; got8 <= 1'b0; state <= ST_IGNORE;
            end else begin
              shreg <= {shreg[6:0], 1'b0};
              sda_drive <= ~shreg[6];
            end
          end
        end
        ST_INCDEC: begin
          if (scl_rise) begin
            shreg[0] <= sda_s; got8 <= 1'b1;
          end else if (scl_fall) begin
            got8 <= 1'b0;
          end
        end
        default: ;
      endcase
    end
  end

  // R7: idle or ignoring slave never holds SDA low
  assert_quiet_when_ignoring_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IGNORE || state == ST_IDLE) |-> !sda_drive);
  // R5: step phase has no acknowledge slots
  assert_incdec_no_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_INCDEC |-> !sda_drive);
  // R3: the first read bit is a driven zero
  assert_read_msb_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_TX && bit_cnt == '0 && !got8) |-> sda_drive);
  // R8: START restarts address reception and releases SDA
  assert_start_abort_R8: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (state == ST_ADDR && !sda_drive));
  // R8: STOP returns to idle
  assert_stop_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_det && !start_det) |=> state == ST_IDLE);
endmodule

// File: rtl/wiper_store.sv
module wiper_store
  import wiper_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  pos_t default_pos,
  input  logic load_en,
  input  pos_t load_val,
  input  logic step_en,
  input  logic step_up,
  output pos_t pos,
  output tap_t tap_sel
);
  localparam pos_t POS_MAX = '1;
  pos_t stepped;

  assign stepped = sat_step(pos, step_up);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos <= default_pos;
      tap_sel <= tap_onehot(default_pos);
    end else if (load_en) begin
      pos <= load_val;
      tap_sel <= tap_onehot(load_val);
    end else if (step_en) begin
      pos <= stepped;
      tap_sel <= tap_onehot(stepped);
    end
  end

  // R6: saturation at both ends
  assert_sat_top_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && !load_en && step_up && pos == POS_MAX) |=> pos == POS_MAX);
  assert_sat_bottom_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && !load_en && !step_up && pos == '0) |=> pos == '0);
  // R2: a load lands on the next cycle
  assert_load_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> pos == $past(load_val));
  // R9: select follows the position, single bit set
  assert_tap_match_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (tap_sel[pos] == 1'b1 && $countones(tap_sel) == 1));
endmodule

// File: rtl/wiper_i2c_ctrl.sv
module wiper_i2c_ctrl
  import wiper_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR  = 7'h28,
  parameter logic [7:0] INC_BYTE  = 8'h58,
  parameter logic [7:0] WIPER_REG = 8'h00,
  parameter logic [7:0] ACC_REG   = 8'h02,
  parameter logic [7:0] ACC_SEL   = 8'h80
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_i,
  input  logic             sda_i,
  input  logic [POS_W-1:0] default_pos,
  output logic             sda_oe,
  output logic [POS_W-1:0] wiper_pos,
  output logic [TAP_N-1:0] tap_sel
);
  logic sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic load_en, step_en, step_up;
  pos_t load_val;

  wiper_bus_sync sync_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  wiper_proto_fsm #(
    .DEV_ADDR(DEV_ADDR), .INC_BYTE(INC_BYTE), .WIPER_REG(WIPER_REG),
    .ACC_REG(ACC_REG), .ACC_SEL(ACC_SEL)
  ) fsm_i (
    .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
    .pos(wiper_pos), .sda_drive(sda_oe), .load_en(load_en),
    .load_val(load_val), .step_en(step_en), .step_up(step_up)
  );

  wiper_store store_i (
    .clk(clk), .rst_n(rst_n), .default_pos(default_pos),
    .load_en(load_en), .load_val(load_val), .step_en(step_en),
    .step_up(step_up), .pos(wiper_pos), .tap_sel(tap_sel)
  );
endmodule

// File: tb/wiper_i2c_ctrl_tb_top.sv
module wiper_i2c_ctrl_tb_top;
  localparam int Q = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic [6:0] dflt = 7'd37;
  logic sda_oe;
  logic [6:0] wpos;
  logic [127:0] taps;
  logic sda_bus;

  assign sda_bus = sda_m & ~sda_oe;
  always #10 clk = ~clk;

  wiper_i2c_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
    .default_pos(dflt), .sda_oe(sda_oe), .wiper_pos(wpos), .tap_sel(taps)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  int exp_pos;
  int exp_acc;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int model_step(int p, bit up);
    int v;
    v = up ? p + 1 : p - 1;
    if (v > 127) v = 127;
    if (v < 0) v = 0;
    return v;
  endfunction

  task automatic wq(); repeat (Q) @(negedge clk); endtask
  task automatic start_c(); sda_m = 1; wq(); scl_m = 1; wq(); sda_m = 0; wq(); scl_m = 0; wq(); endtask
  task automatic stop_c(); sda_m = 0; wq(); scl_m = 1; wq(); sda_m = 1; wq(); endtask
  task automatic clk_bit(input bit b, output bit obs);
    sda_m = b; wq(); scl_m = 1; wq(); obs = sda_bus; wq(); scl_m = 0; wq();
  endtask
  task automatic send_byte(input logic [7:0] b, output bit ack);
    bit obs;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], obs);
    clk_bit(1'b1, obs);
    ack = !obs;
  endtask
  task automatic read_byte(output logic [7:0] v);
    bit obs;
    for (int i = 7; i >= 0; i--) begin clk_bit(1'b1, obs); v[i] = obs; end
    clk_bit(1'b1, obs);
  endtask
  task automatic settle(); repeat (8) @(negedge clk); endtask

  task automatic wr(input logic [7:0] rg, input logic [7:0] d, output bit a0, output bit a1, output bit a2);
    start_c(); send_byte(8'h50, a0); send_byte(rg, a1); send_byte(d, a2); stop_c(); settle();
  endtask
  task automatic rd(output logic [7:0] v, output bit a0, output bit a1, output bit a2);
    start_c(); send_byte(8'h50, a0); send_byte(8'h00, a1);
    start_c(); send_byte(8'h51, a2); read_byte(v); stop_c(); settle();
  endtask
  task automatic incdec(input int n, input logic [31:0] bits, output bit a0, output bit a1, output bit pulled);
    bit obs;
    start_c(); send_byte(8'h58, a0); send_byte(8'h00, a1);
    pulled = 0;
    for (int i = 0; i < n; i++) begin
      clk_bit(bits[i], obs);
      if (bits[i] && !obs) pulled = 1;
    end
    stop_c(); settle();
  endtask

  task automatic check_pos(input string req);
    int idx;
    idx = -1;
    for (int i = 0; i < 128; i++) if (taps[i]) idx = i;
    chk(wpos == 7'(exp_pos), req, int'(wpos), exp_pos);
    chk(taps == (128'b1 << exp_pos), "R9 tap_sel one-hot index", idx, exp_pos);
  endtask

  task automatic do_write(input logic [7:0] d, input string req);
    bit a0, a1, a2;
    wr(8'h00, d, a0, a1, a2);
    chk(a0 && a1 && a2, "R2 write acks", {a0, a1, a2}, 7);
    if (exp_acc == 8'h80) exp_pos = int'(d[6:0]);
    check_pos(req);
  endtask

  task automatic do_read(input string req);
    logic [7:0] v;
    bit a0, a1, a2;
    rd(v, a0, a1, a2);
    chk(a0 && a1 && a2, "R3 read acks", {a0, a1, a2}, 7);
    chk(v == {1'b0, 7'(exp_pos)}, req, int'(v), exp_pos);
  endtask

  task automatic do_incdec(input int n, input logic [31:0] bits, input string req);
    bit a0, a1, pulled;
    incdec(n, bits, a0, a1, pulled);
    chk(a0 && a1, "R5 step address acks", {a0, a1}, 3);
    chk(!pulled, "R5 no ack in step phase", pulled, 0);
    for (int i = 0; i < n; i++) exp_pos = model_step(exp_pos, bits[i]);
    check_pos(req);
  endtask

  initial begin
    bit a0, a1, a2, obs;
    void'($urandom(32'd2024));
    exp_acc = 8'h80;
    repeat (6) @(negedge clk);
    // R1: reset loads default, SDA released
    chk(wpos == dflt, "R1 reset position", int'(wpos), int'(dflt));
    chk(sda_oe == 1'b0, "R1 sda released in reset", sda_oe, 0);
    rst_n = 1'b1;
    settle();
    exp_pos = 37;
    check_pos("R1 position after reset");

    // R2: MSB of data ignored
    do_write(8'hFF, "R2 write 0xFF gives 127");
    do_write(8'h15, "R2 write 0x15");
    do_read("R3 read back 0x15");

    // R5 / R6
    do_incdec(5, 32'h1F, "R5 five steps up");
    do_write(8'h7D, "R2 write 125");
    do_incdec(6, 32'h3F, "R6 saturate at 127");
    do_write(8'h02, "R2 write 2");
    do_incdec(5, 32'h00, "R6 saturate at 0");
    do_write(8'd50, "R2 write 50");
    do_incdec(10, 32'h2CE, "R5 mixed direction stream");
    do_read("R3 read after stepping");

    // R7: stray address, bad register, step with wrong register
    start_c(); send_byte(8'h52, a0); send_byte(8'h00, a1); send_byte(8'h11, a2); stop_c(); settle();
    chk(!a0 && !a1 && !a2, "R7 stray address not acked", {a0, a1, a2}, 0);
    check_pos("R7 stray address no effect");
    wr(8'h05, 8'h22, a0, a1, a2);
    chk(a0 && !a1 && !a2, "R7 bad register not acked", {a0, a1, a2}, 4);
    check_pos("R7 bad register no effect");
    start_c(); send_byte(8'h58, a0); send_byte(8'h02, a1);
    for (int i = 0; i < 4; i++) clk_bit(1'b1, obs);
    stop_c(); settle();
    chk(a0 && !a1, "R7 step mode with register 0x02 not acked", {a0, a1}, 2);
    check_pos("R7 step mode bad register no effect");

    // R4: access byte gating
    wr(8'h02, 8'h00, a0, a1, a2);
    chk(a0 && a1 && a2, "R4 access write acks", {a0, a1, a2}, 7);
    exp_acc = 8'h00;
    do_write(8'h33, "R4 write blocked while access byte is 0x00");
    do_read("R4 read while blocked");
    wr(8'h02, 8'h80, a0, a1, a2);
    exp_acc = 8'h80;
    do_write(8'h33, "R4 write allowed after access byte 0x80");

    // R8: aborted data byte, restart mid address
    start_c(); send_byte(8'h50, a0); send_byte(8'h00, a1);
    for (int i = 0; i < 4; i++) clk_bit(1'b1, obs);
    start_c(); stop_c(); settle();
    check_pos("R8 cut data byte no effect");
    start_c();
    for (int i = 0; i < 3; i++) clk_bit(1'b0, obs);
    start_c(); send_byte(8'h50, a0); send_byte(8'h00, a1); send_byte(8'h44, a2); stop_c(); settle();
    chk(a0 && a1 && a2, "R8 restart then write acks", {a0, a1, a2}, 7);
    exp_pos = 8'h44;
    check_pos("R8 write after restart");

    // Random mix
    for (int it = 0; it < 50; it++) begin
      int op;
      op = int'($urandom % 5);
      case (op)
        0: do_write(8'($urandom), "R2 random write");
        1: do_read("R3 random read");
        2: begin
          int n;
          n = 1 + int'($urandom % 24);
          do_incdec(n, $urandom, "R5 random step stream");
        end
        3: begin
          logic [7:0] d;
          d = ($urandom % 2) ? 8'h80 : 8'($urandom);
          wr(8'h02, d, a0, a1, a2);
          chk(a0 && a1 && a2, "R4 random access write acks", {a0, a1, a2}, 7);
          exp_acc = int'(d);
        end
        default: begin
          logic [7:0] b;
          b = 8'($urandom);
          if (b == 8'h50 || b == 8'h51 || b == 8'h58) b = 8'h9C;
          start_c(); send_byte(b, a0); send_byte(8'h00, a1); stop_c(); settle();
          chk(!a0 && !a1, "R7 random stray address", {a0, a1}, 0);
          check_pos("R7 random stray no effect");
        end
      endcase
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R8 watchdog expired actual 0 expected 1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule